// File: doc/BRIEF.md
# Sign-Magnitude Accumulator Processor with Interrupt Stage

This block is a small 16-bit processor built around one accumulator. Each instruction passes through a fetch phase, an execute phase and a final interrupt-check phase. All memory traffic goes through a single-cycle synchronous port: the processor drives an address and a read or write strobe, and read data comes back in the next cycle, where it is latched into a buffer register. Every instruction word carries a 4-bit operation code in bits 15:12 and a 12-bit word address in bits 11:0. Data words are sign-magnitude: bit 15 is the sign and bits 14:0 are the magnitude.

One interrupt request line is checked at each instruction boundary. When the request is accepted, the processor pulses an acknowledge and saves its status word and program counter on a four-entry internal stack. It then clears interrupt enable and continues at a fixed handler address. A return operation pops the saved pair, so the interrupted program resumes at the instruction after the one it was executing.

A halt input parks the processor between instructions. Debug outputs show the program counter, the instruction register, the accumulator and the status bits. This lets a test harness single-step programs and inspect their effect.

Top module: `acc_cpu`

## Requirements
- R1: After reset the program counter equals the RESET_PC parameter, the accumulator, instruction register and overflow flag are 0, interrupt enable is 1, the stack error is 0, and the processor is halted-idle (halted=1) with no strobe.
- R2: A fetch drives mem_rd with mem_addr equal to the program counter, loads the returned word into the instruction register in the next cycle and adds one to the program counter.
- R3: Operation code 4'b0001 copies the addressed word into the accumulator.
- R4: Operation code 4'b0010 drives mem_wr for one cycle with mem_addr equal to bits 11:0 of the instruction and mem_wdata equal to the accumulator.
- R5: Operation code 4'b0101 adds the addressed word to the accumulator in sign-magnitude form. Equal signs add the magnitudes and keep the sign. Unequal signs subtract the smaller magnitude from the larger and take the sign of the larger.
- R6: Each add sets dbg_psw[1] (overflow) when the magnitude sum exceeds 15 bits and clears it otherwise. On overflow the result keeps the low 15 bits of the magnitude.
- R7: An add whose result magnitude is zero always yields 16'h0000, never 16'h8000.
- R8: After each instruction, if dbg_psw[0] (interrupt enable) is 1 and irq is high, irq_ack is high for exactly one cycle. The pair {overflow, enable, PC} is pushed on the stack, PC becomes the HANDLER parameter (default 12'h100) and enable is cleared.
- R9: While interrupt enable is 0, irq produces no acknowledge and does not redirect the program counter.
- R10: Operation code 4'b1111 pops the stack and restores the overflow flag, interrupt enable and program counter saved there.
- R11: The stack holds 4 entries. A pop on an empty stack, or a push on a full one, sets the sticky stk_err output and leaves the program counter, status bits and stored entries unchanged.
- R12: Operation codes other than 0001, 0010, 0101 and 1111 change nothing except the fetch update of PC and IR, and issue no operand access.
- R13: halt is sampled only at an instruction boundary. While halted=1 the processor drives no strobe and its state does not change.
- R14: Starting at 12'h300, the words 16'h1940, 16'h5941 and 16'h2941, with word 12'h940 = 3 and word 12'h941 = 2, leave 5 in word 12'h941 and PC at 12'h303.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Word address for the current access |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata in the next cycle |
| mem_wr | output | 1 | Write strobe, accepted at the clock edge |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data, returned one cycle after mem_rd |
| irq | input | 1 | Level interrupt request |
| irq_ack | output | 1 | One-cycle acknowledge when the request is accepted |
| halt | input | 1 | Park at the next instruction boundary |
| halted | output | 1 | Processor is parked between instructions |
| dbg_pc | output | 12 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_ac | output | 16 | Accumulator |
| dbg_psw | output | 2 | Status: bit 1 overflow, bit 0 interrupt enable |
| stk_err | output | 1 | Sticky stack misuse flag |

## Verification
The add path is driven through a table of operand pairs that covers equal positive signs and equal negative signs. It also covers mixed signs with the larger magnitude on either side, exact cancellation in both sign orders, and negative zero plus negative zero. A separate group of pairs overflows with positive and with negative sign. Together these separate sign selection, borrow direction, the overflow flag and the rule that folds negative zero to positive zero. An interrupt is raised while the overflow flag is set. The handler then clears the flag, which shows that the return restores the saved status rather than keeping the current one. Requests held high inside the handler, a return on an empty stack, an undefined code and a long halt cover the paths where nothing may change.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int          DW       = 16,
  parameter int          AW       = 12,
  parameter int          DEPTH    = 4,
  parameter logic [11:0] RESET_PC = 12'h000,
  parameter logic [11:0] HANDLER  = 12'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          irq,
  output logic          irq_ack,
  input  logic          halt,
  output logic          halted,
  output logic [AW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_ir,
  output logic [DW-1:0] dbg_ac,
  output logic [1:0]    dbg_psw,
  output logic          stk_err
);
  localparam int MW  = DW - 1;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW  = AW + 2;

  localparam logic [3:0] OP_LD  = 4'b0001;
  localparam logic [3:0] OP_ST  = 4'b0010;
  localparam logic [3:0] OP_ADD = 4'b0101;
  localparam logic [3:0] OP_RET = 4'b1111;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_EXEC, S_EWAIT, S_WB, S_ICHK, S_IACK
  } state_t;

  state_t           state;
  logic [AW-1:0]    pc;
  logic [DW-1:0]    ir, ac, mbr;
  logic             psw_ie, psw_ovf, err;
  logic [SPW-1:0]   sp;
  logic [EW-1:0]    stk [DEPTH];

  wire [3:0]  op      = ir[DW-1:DW-4];
  wire        take    = psw_ie && irq;
  wire        st_full = (sp == SPW'(DEPTH));
  wire        st_emp  = (sp == '0);
  wire [SPW-1:0] sp_m1 = sp - SPW'(1);
  wire [EW-1:0]  top   = stk[sp_m1[IW-1:0]];

  // sign-magnitude adder on AC and MBR
  wire          a_s = ac[DW-1];
  wire          b_s = mbr[DW-1];
  wire [MW-1:0] a_m = ac[MW-1:0];
  wire [MW-1:0] b_m = mbr[MW-1:0];
  wire          same = (a_s == b_s);
  wire [MW:0]   msum = {1'b0, a_m} + {1'b0, b_m};
  wire          a_ge = (a_m >= b_m);
  wire [MW-1:0] mdif = a_ge ? (a_m - b_m) : (b_m - a_m);
  wire [MW-1:0] r_m  = same ? msum[MW-1:0] : mdif;
  wire          r_s  = same ? a_s : (a_ge ? a_s : b_s);
  wire [DW-1:0] sum  = {r_s && (r_m != '0), r_m};
  wire          ovf_n = same && msum[MW];

  assign halted    = (state == S_IDLE);
  assign irq_ack   = (state == S_IACK);
  assign mem_rd    = (state == S_FETCH) ||
                     (state == S_EXEC && (op == OP_LD || op == OP_ADD));
  assign mem_wr    = (state == S_EXEC) && (op == OP_ST);
  assign mem_addr  = (state == S_FETCH) ? pc : ir[AW-1:0];
  assign mem_wdata = ac;
  assign dbg_pc    = pc;
  assign dbg_ir    = ir;
  assign dbg_ac    = ac;
  assign dbg_psw   = {psw_ovf, psw_ie};
  assign stk_err   = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pc      <= RESET_PC;
      ir      <= '0;
      ac      <= '0;
      mbr     <= '0;
      psw_ie  <= 1'b1;
      psw_ovf <= 1'b0;
      err     <= 1'b0;
      sp      <= '0;
    end else begin
      case (state)
        S_IDLE:  if (!halt) state <= S_FETCH;
        S_FETCH: state <= S_FWAIT;
        S_FWAIT: begin
          ir    <= mem_rdata;
          mbr   <= mem_rdata;
          pc    <= pc + AW'(1);
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_ICHK;
          if (op == OP_LD || op == OP_ADD) state <= S_EWAIT;
          if (op == OP_RET) begin
            if (st_emp) err <= 1'b1;
            else begin
              {psw_ovf, psw_ie, pc} <= top;
              sp <= sp_m1;
            end
          end
        end
        S_EWAIT: begin
          mbr   <= mem_rdata;
          state <= S_WB;
        end
        S_WB: begin
          if (op == OP_LD) ac <= mbr;
          else begin
            ac      <= sum;
            psw_ovf <= ovf_n;
          end
          state <= S_ICHK;
        end
        S_ICHK: begin
          if (take)      state <= S_IACK;
          else if (halt) state <= S_IDLE;
          else           state <= S_FETCH;
        end
        S_IACK: begin
          if (st_full) err <= 1'b1;
          else begin
            sp     <= sp + SPW'(1);
            pc     <= HANDLER;
            psw_ie <= 1'b0;
          end
          state <= halt ? S_IDLE : S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && state == S_IACK && !st_full)
      stk[sp[IW-1:0]] <= {psw_ovf, psw_ie, pc};
  end

  // R13
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));
  // R13
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && halt) |=> (halted && $stable(pc) && $stable(ac)));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FWAIT) |=> (pc == AW'($past(pc) + AW'(1))));
  // R8
  ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(irq && psw_ie));
  // R8
  ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !st_full) |=> (!psw_ie && pc == HANDLER && !irq_ack));
  // R9
  ie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ICHK && !psw_ie) |=> !irq_ack);
  // R7
  no_negzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && op == OP_ADD) |=> (ac != {1'b1, {MW{1'b0}}}));
  // R11
  sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        irq = 1'b0;
  logic        irq_ack;
  logic        halt = 1'b1;
  logic        halted;
  logic [11:0] dbg_pc;
  logic [15:0] dbg_ir, dbg_ac;
  logic [1:0]  dbg_psw;
  logic        stk_err;

  logic [15:0] mem [4096];
  int checks = 0;
  int errors = 0;
  int acks = 0;
  int strobes = 0;

  always #4 clk = ~clk;

  acc_cpu #(.RESET_PC(12'h300), .HANDLER(12'h100)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq(irq), .irq_ack(irq_ack), .halt(halt), .halted(halted),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_ac(dbg_ac), .dbg_psw(dbg_psw),
    .stk_err(stk_err));

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (irq_ack) acks++;
    if (mem_rd || mem_wr) strobes++;
  end

  // {a, b, expected sum, expected overflow}
  localparam logic [48:0] VEC [10] = '{
    {16'h0003, 16'h0002, 16'h0005, 1'b0},
    {16'h8003, 16'h0002, 16'h8001, 1'b0},
    {16'h0002, 16'h8005, 16'h8003, 1'b0},
    {16'h8004, 16'h8004, 16'h8008, 1'b0},
    {16'h0005, 16'h8005, 16'h0000, 1'b0},
    {16'h8005, 16'h0005, 16'h0000, 1'b0},
    {16'h8000, 16'h8000, 16'h0000, 1'b0},
    {16'h7FFF, 16'h0002, 16'h0001, 1'b1},
    {16'hFFFF, 16'h8002, 16'h8001, 1'b1},
    {16'h4000, 16'h4000, 16'h0000, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    halt  = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic step();
    int n;
    @(negedge clk);
    halt = 1'b0;
    n = 0;
    while (halted && n < 50) begin @(negedge clk); n++; end
    halt = 1'b1;
    n = 0;
    while (!halted && n < 50) begin @(negedge clk); n++; end
    if (n >= 50) chk(1'b0, "R13", "step timeout", 0, 1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a0, s0;
    clear_mem();
    do_reset();
    // R1 reset state
    chk(dbg_pc == 12'h300 && dbg_ac == 0 && dbg_ir == 0, "R1", "pc/ac/ir",
        {dbg_pc, dbg_ac[3:0], dbg_ir}, {12'h300, 4'h0, 16'h0});
    chk(dbg_psw == 2'b01 && !stk_err && halted && !mem_rd && !mem_wr, "R1",
        "psw/err/idle", {dbg_psw, stk_err, halted, mem_rd, mem_wr}, 6'b010100);

    // R5 R6 R7 R14: table of adds, program loads a, adds b, stores result
    foreach (VEC[k]) begin
      clear_mem();
      mem[12'h300] = 16'h1940;
      mem[12'h301] = 16'h5941;
      mem[12'h302] = 16'h2941;
      mem[12'h940] = VEC[k][48:33];
      mem[12'h941] = VEC[k][32:17];
      do_reset();
      step(); step(); step();
      chk(mem[12'h941] == VEC[k][16:1], "R5", $sformatf("stored sum #%0d", k),
          mem[12'h941], VEC[k][16:1]);
      chk(dbg_psw[1] == VEC[k][0], "R6", $sformatf("overflow #%0d", k),
          dbg_psw[1], VEC[k][0]);
      if (VEC[k][16:1] == 16'h0000)
        chk(dbg_ac == 16'h0000, "R7", $sformatf("positive zero #%0d", k),
            dbg_ac, 0);
      chk(dbg_pc == 12'h303, "R14", $sformatf("final pc #%0d", k), dbg_pc, 12'h303);
    end

    // R2 R3 fetch and load
    clear_mem();
    mem[12'h300] = 16'h1940;
    mem[12'h940] = 16'h8123;
    do_reset();
    step();
    chk(dbg_ir == 16'h1940 && dbg_pc == 12'h301, "R2", "fetch ir/pc",
        {dbg_ir, dbg_pc}, {16'h1940, 12'h301});
    chk(dbg_ac == 16'h8123, "R3", "load value", dbg_ac, 16'h8123);

    // R4 store writes the accumulator to the addressed word only
    mem[12'h301] = 16'h2955;
    step();
    chk(mem[12'h955] == 16'h8123 && mem[12'h956] == 0, "R4", "store target",
        {mem[12'h955], mem[12'h956]}, {16'h8123, 16'h0});

    // R12 undefined code: no operand access, AC/memory untouched
    mem[12'h302] = 16'h3955;
    s0 = strobes;
    step();
    chk(strobes - s0 == 1, "R12", "only fetch strobe", strobes - s0, 1);
    chk(dbg_ac == 16'h8123 && mem[12'h955] == 16'h8123 && dbg_pc == 12'h303
        && dbg_psw == 2'b01, "R12", "state unchanged",
        {dbg_ac, dbg_pc}, {16'h8123, 12'h303});

    // R13 long halt: no strobe, nothing moves
    s0 = strobes;
    repeat (40) @(negedge clk);
    chk(strobes == s0 && dbg_pc == 12'h303 && halted, "R13", "halt quiet",
        strobes - s0, 0);

    // R8 R9 R10 interrupt entry, masking, return with status restore
    clear_mem();
    mem[12'h300] = 16'h1942;
    mem[12'h301] = 16'h5943;
    mem[12'h942] = 16'h7FFF;
    mem[12'h943] = 16'h0001;
    mem[12'h100] = 16'h1940;
    mem[12'h101] = 16'h5940;
    mem[12'h102] = 16'hF000;
    mem[12'h940] = 16'h0003;
    do_reset();
    step();
    a0 = acks;
    irq = 1'b1;
    step();
    chk(acks - a0 == 1, "R8", "one ack", acks - a0, 1);
    chk(dbg_pc == 12'h100 && dbg_psw == 2'b10, "R8", "vector and psw",
        {dbg_pc, dbg_psw}, {12'h100, 2'b10});
    step();
    step();
    chk(acks - a0 == 1 && dbg_pc == 12'h102, "R9", "masked request",
        {acks - a0, dbg_pc}, {32'd1, 12'h102});
    chk(dbg_ac == 16'h0006 && dbg_psw == 2'b00, "R9", "handler add",
        {dbg_ac, dbg_psw}, {16'h0006, 2'b00});
    irq = 1'b0;
    step();
    chk(dbg_pc == 12'h302 && dbg_psw == 2'b11 && !stk_err, "R10",
        "return restore", {dbg_pc, dbg_psw, stk_err}, {12'h302, 2'b11, 1'b0});

    // R11 return on empty stack
    clear_mem();
    mem[12'h300] = 16'hF000;
    do_reset();
    step();
    chk(stk_err && dbg_pc == 12'h301 && dbg_psw == 2'b01, "R11",
        "empty pop", {stk_err, dbg_pc, dbg_psw}, {1'b1, 12'h301, 2'b01});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule